// File: doc/BRIEF.md
# Table-Programmed Factorial Sequencer

This block runs a small register-transfer datapath under the control of a writable program table. The datapath holds two registers: an accumulator, which also drives the result output, and a counter. Between them sit a truncating multiplier and a wrapping decrementer. Each register loads only when the current program row enables it. A sequencer steps through the table one row per clock cycle. It branches on a single status bit, which is true when the counter equals zero.

The same hardware can compute either N*(N-1) or N! with no change to the logic. Only the rows written into the table differ. The factorial loop relies on the zero test. Software writes the table through a simple write port, places N on the operand input and pulses start. When the sequencer reaches a row marked halt, the done output goes high for one cycle. The result stays on its port until the next run begins.

Top module: `fact_engine`

## Requirements
- R1: After reset, done is 0 and result is 0. Every table row is a halt row, so a start issued before any write ends with done after one step and result 0.
- R2: A row written with prog_we high at a rising edge takes prog_wdata at prog_addr. The row word is {branch[AW], next[AW], halt(bit 5), acc_load(bit 4), acc_src(bits 3:2), cnt_load(bit 1), cnt_src(bit 0)}. AW is 3 by default.
- R3: A start sampled while idle sets the row pointer to 0. Each following cycle executes one row. A non-halt row moves to its branch field when the counter is zero, and to its next field otherwise.
- R4: Accumulator source codes are 0 for one, 1 for N, 2 for accumulator times counter, and 3 for counter minus one. Counter source codes are 0 for N and 1 for counter minus one.
- R5: A register whose load bit is 0 in the executing row keeps its value.
- R6: Both registers may load in the same row. Each one then uses the values the registers held before that row.
- R7: A halt row loads nothing, drives done high for exactly one cycle and returns to idle. With S rows executed before the halt row, done is high after the rising edge S+1 edges after the edge that sampled start.
- R8: A start strobe during a run has no effect on the result or on the run length.
- R9: Between runs, result holds its value even across table writes and changes of N.
- R10: Arithmetic is unsigned and wraps: the product is taken modulo 2^WIDTH, and decrementing zero gives all ones.
- R11: With the factorial program loaded, the result is N! modulo 2^WIDTH, and both 0! and 1! give 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Run strobe, honoured only while idle |
| n_in | input | WIDTH | Operand N |
| prog_we | input | 1 | Program table write enable |
| prog_addr | input | AW | Program row to write |
| prog_wdata | input | 6+2*AW | Control word to write |
| result | output | WIDTH | Accumulator value |
| done | output | 1 | One-cycle pulse when a halt row is reached |

## Verification
The assertions check the following on every cycle:
- Each register holds whenever its load strobe is low.
- done is a single-cycle pulse that always follows a halt row.
- The row pointer goes to the branch field on a zero counter and to the next field otherwise.
- A start while idle always resets the pointer to row 0.
- The result is stable while the sequencer is idle.

Only the bench scenarios can show that the written programs compute the right values, including wraparound of the product and of the decrement. The bench scenarios also show the exact run lengths, the effect of the zero test on loop count, and that a start strobe in the middle of a run changes nothing.

// File: rtl/fact_pkg.sv
package fact_pkg;

  // Low six bits of every program row hold the per-step control flags;
  // the next and branch row fields sit above them.
  localparam int CTL_FLAG_BITS = 6;

  typedef enum logic [1:0] {
    ACC_ONE  = 2'd0,
    ACC_N    = 2'd1,
    ACC_PROD = 2'd2,
    ACC_DEC  = 2'd3
  } acc_src_e;

  typedef enum logic {
    CNT_N   = 1'b0,
    CNT_DEC = 1'b1
  } cnt_src_e;

  typedef struct packed {
    logic     halt;
    logic     acc_load;
    acc_src_e acc_src;
    logic     cnt_load;
    cnt_src_e cnt_src;
  } ctl_flags_t;

  // Reset content of a row: halt, no loads.
  localparam logic [CTL_FLAG_BITS-1:0] HALT_FLAGS = 6'b10_0000;

endpackage

// File: rtl/fact_prog_table.sv
module fact_prog_table
  import fact_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int AW    = 3,
  parameter int CW    = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [CW-1:0] wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [CW-1:0] rd_data
);

  localparam logic [CW-1:0] RESET_ROW = CW'(HALT_FLAGS);

  logic [CW-1:0] rows [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_row
    logic hit;
    assign hit = wr_en && (wr_addr == AW'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   rows[g] <= RESET_ROW;
      else if (hit) rows[g] <= wr_data;
    end
  end

  always_comb begin
    rd_data = RESET_ROW;
    for (int i = 0; i < DEPTH; i++) begin
      if (rd_addr == AW'(i)) rd_data = rows[i];
    end
  end

endmodule

// File: rtl/fact_datapath.sv
module fact_datapath
  import fact_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] n_in,
  input  logic             acc_load,
  input  acc_src_e         acc_src,
  input  logic             cnt_load,
  input  cnt_src_e         cnt_src,
  output logic [WIDTH-1:0] acc_q,
  output logic [WIDTH-1:0] cnt_q,
  output logic             cnt_zero
);

  function automatic logic [WIDTH-1:0] mul_wrap(input logic [WIDTH-1:0] a,
                                                input logic [WIDTH-1:0] b);
    logic [2*WIDTH-1:0] full;
    full = a * b;
    return full[WIDTH-1:0];
  endfunction

  function automatic logic [WIDTH-1:0] dec_wrap(input logic [WIDTH-1:0] a);
    return a - WIDTH'(1);
  endfunction

  logic [WIDTH-1:0] prod_w, dec_w, acc_d, cnt_d;

  assign prod_w   = mul_wrap(acc_q, cnt_q);
  assign dec_w    = dec_wrap(cnt_q);
  assign cnt_zero = (cnt_q == '0);

  always_comb begin
    case (acc_src)
      ACC_ONE:  acc_d = WIDTH'(1);
      ACC_N:    acc_d = n_in;
      ACC_PROD: acc_d = prod_w;
      ACC_DEC:  acc_d = dec_w;
      default:  acc_d = acc_q;
    endcase
  end

  always_comb begin
    case (cnt_src)
      CNT_N:   cnt_d = n_in;
      CNT_DEC: cnt_d = dec_w;
      default: cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      cnt_q <= '0;
    end else begin
      if (acc_load) acc_q <= acc_d;
      if (cnt_load) cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/fact_sequencer.sv
module fact_sequencer
  import fact_pkg::*;
#(
  parameter int AW = 3,
  parameter int CW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          cnt_zero,
  input  logic [CW-1:0] row,
  output logic [AW-1:0] pc,
  output logic [AW-1:0] next_row,
  output logic [AW-1:0] branch_row,
  output logic          running,
  output logic          stepping,
  output logic          halt_row,
  output logic          acc_load,
  output acc_src_e      acc_src,
  output logic          cnt_load,
  output cnt_src_e      cnt_src,
  output logic          done
);

  ctl_flags_t flags;

  assign flags      = ctl_flags_t'(row[CTL_FLAG_BITS-1:0]);
  assign next_row   = row[CTL_FLAG_BITS +: AW];
  assign branch_row = row[CTL_FLAG_BITS+AW +: AW];

  assign halt_row = running && flags.halt;
  assign stepping = running && !flags.halt;
  assign acc_load = stepping && flags.acc_load;
  assign cnt_load = stepping && flags.cnt_load;
  assign acc_src  = flags.acc_src;
  assign cnt_src  = flags.cnt_src;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running <= 1'b0;
      pc      <= '0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!running) begin
        if (start) begin
          running <= 1'b1;
          pc      <= '0;
        end
      end else if (flags.halt) begin
        running <= 1'b0;
        done    <= 1'b1;
      end else begin
        pc <= cnt_zero ? branch_row : next_row;
      end
    end
  end

endmodule

// File: rtl/fact_engine.sv
module fact_engine
  import fact_pkg::*;
#(
  parameter int WIDTH = 32,
  parameter int DEPTH = 8,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = CTL_FLAG_BITS + 2 * AW
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [WIDTH-1:0] n_in,
  input  logic             prog_we,
  input  logic [AW-1:0]    prog_addr,
  input  logic [CW-1:0]    prog_wdata,
  output logic [WIDTH-1:0] result,
  output logic             done
);

  logic [CW-1:0]    row_w;
  logic [AW-1:0]    pc_w, next_w, branch_w;
  logic             running_w, stepping_w, halt_w;
  logic             acc_load_w, cnt_load_w, cnt_zero_w;
  acc_src_e         acc_src_w;
  cnt_src_e         cnt_src_w;
  logic [WIDTH-1:0] cnt_w;

  fact_prog_table #(.DEPTH(DEPTH), .AW(AW), .CW(CW)) u_table (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (prog_we),
    .wr_addr (prog_addr),
    .wr_data (prog_wdata),
    .rd_addr (pc_w),
    .rd_data (row_w)
  );

  fact_sequencer #(.AW(AW), .CW(CW)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .cnt_zero   (cnt_zero_w),
    .row        (row_w),
    .pc         (pc_w),
    .next_row   (next_w),
    .branch_row (branch_w),
    .running    (running_w),
    .stepping   (stepping_w),
    .halt_row   (halt_w),
    .acc_load   (acc_load_w),
    .acc_src    (acc_src_w),
    .cnt_load   (cnt_load_w),
    .cnt_src    (cnt_src_w),
    .done       (done)
  );

  fact_datapath #(.WIDTH(WIDTH)) u_dp (
    .clk      (clk),
    .rst_n    (rst_n),
    .n_in     (n_in),
    .acc_load (acc_load_w),
    .acc_src  (acc_src_w),
    .cnt_load (cnt_load_w),
    .cnt_src  (cnt_src_w),
    .acc_q    (result),
    .cnt_q    (cnt_w),
    .cnt_zero (cnt_zero_w)
  );

endmodule

// File: rtl/fact_engine_chk.sv
module fact_engine_chk #(
  parameter int WIDTH = 32,
  parameter int AW    = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             done,
  input logic [WIDTH-1:0] result,
  input logic [WIDTH-1:0] cnt_q,
  input logic             cnt_zero,
  input logic             running,
  input logic             stepping,
  input logic             halt_row,
  input logic             acc_load,
  input logic             cnt_load,
  input logic [AW-1:0]    pc,
  input logic [AW-1:0]    next_row,
  input logic [AW-1:0]    branch_row
);

  assert_acc_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_load |=> $stable(result));

  assert_cnt_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_load |=> $stable(cnt_q));

  assert_start_row0_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!running && start) |=> (running && pc == '0));

  assert_zero_branch_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (stepping && cnt_zero) |=> (pc == $past(branch_row)));

  assert_nonzero_next_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (stepping && !cnt_zero) |=> (pc == $past(next_row)));

  assert_halt_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
    halt_row |=> (done && !running));

  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_run_persists_R8: assert property (@(posedge clk) disable iff (!rst_n)
    stepping |=> running);

  assert_idle_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !running |=> $stable(result));

endmodule

bind fact_engine fact_engine_chk #(.WIDTH(WIDTH), .AW(AW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .start      (start),
  .done       (done),
  .result     (result),
  .cnt_q      (cnt_w),
  .cnt_zero   (cnt_zero_w),
  .running    (running_w),
  .stepping   (stepping_w),
  .halt_row   (halt_w),
  .acc_load   (acc_load_w),
  .cnt_load   (cnt_load_w),
  .pc         (pc_w),
  .next_row   (next_w),
  .branch_row (branch_w)
);

// File: tb/tb_fact_engine.sv
`timescale 1ns/1ps
module tb_fact_engine;

  localparam int W  = 32;
  localparam int AW = 3;
  localparam int CW = 6 + 2 * AW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [W-1:0]  n_in = '0;
  logic          prog_we = 1'b0;
  logic [AW-1:0] prog_addr = '0;
  logic [CW-1:0] prog_wdata = '0;
  logic [W-1:0]  result;
  logic          done;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  fact_engine #(.WIDTH(W), .DEPTH(8)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .n_in(n_in),
    .prog_we(prog_we), .prog_addr(prog_addr), .prog_wdata(prog_wdata),
    .result(result), .done(done)
  );

  // Stimulus table: program mode (0 = merged N*(N-1), 1 = factorial,
  // 2 = four-step N*(N-1)), operand, expected result.
  localparam int NV = 14;
  localparam logic [1:0] V_MODE [NV] = '{1, 1, 1, 1, 1, 1, 1, 0, 0, 0, 0, 0, 2, 2};
  localparam logic [W-1:0] V_N   [NV] = '{0, 1, 2, 3, 5, 12, 13, 0, 1, 7, 65536, 65537, 9, 2};
  localparam logic [W-1:0] V_EXP [NV] = '{1, 1, 2, 6, 120, 479001600, 1932053504,
                                          0, 0, 42, 32'd4294901760, 65536, 72, 2};

  task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic logic [CW-1:0] mkw(input logic halt, input logic al, input logic [1:0] asel,
                                        input logic cl, input logic csel,
                                        input logic [AW-1:0] nxt, input logic [AW-1:0] brn);
    return {brn, nxt, halt, al, asel, cl, csel};
  endfunction

  task automatic wr(input int addr, input logic [CW-1:0] w);
    @(negedge clk);
    prog_we = 1'b1; prog_addr = AW'(addr); prog_wdata = w;
    @(negedge clk);
    prog_we = 1'b0;
  endtask

  task automatic load_prog(input int mode);
    if (mode == 1) begin
      wr(0, mkw(0, 1, 2'd0, 1, 1'b0, 3'd1, 3'd1)); // acc<=1, cnt<=N
      wr(1, mkw(0, 0, 2'd0, 0, 1'b0, 3'd2, 3'd3)); // zero test
      wr(2, mkw(0, 1, 2'd2, 1, 1'b1, 3'd1, 3'd1)); // acc<=acc*cnt, cnt<=cnt-1
      wr(3, mkw(1, 0, 2'd0, 0, 1'b0, 3'd0, 3'd0));
    end else if (mode == 0) begin
      wr(0, mkw(0, 0, 2'd0, 1, 1'b0, 3'd1, 3'd1)); // cnt<=N
      wr(1, mkw(0, 1, 2'd3, 0, 1'b0, 3'd2, 3'd2)); // acc<=cnt-1
      wr(2, mkw(0, 1, 2'd2, 0, 1'b0, 3'd3, 3'd3)); // acc<=acc*cnt
      wr(3, mkw(1, 0, 2'd0, 0, 1'b0, 3'd0, 3'd0));
    end else begin
      wr(0, mkw(0, 0, 2'd0, 1, 1'b0, 3'd1, 3'd1)); // cnt<=N
      wr(1, mkw(0, 1, 2'd1, 0, 1'b0, 3'd2, 3'd2)); // acc<=N
      wr(2, mkw(0, 0, 2'd0, 1, 1'b1, 3'd3, 3'd3)); // cnt<=cnt-1
      wr(3, mkw(0, 1, 2'd2, 0, 1'b0, 3'd4, 3'd4)); // acc<=acc*cnt
      wr(4, mkw(1, 0, 2'd0, 0, 1'b0, 3'd0, 3'd0));
    end
  endtask

  // Pulses start, counts edges after the sampling edge until done is seen.
  // poke > 0 raises start again during that cycle of the run.
  task automatic run(input logic [W-1:0] n, input int poke, output int lat);
    @(negedge clk);
    n_in = n; start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    lat = 0;
    for (int k = 0; k < 1000; k++) begin
      @(posedge clk);
      lat++;
      @(negedge clk);
      start = (lat == poke);
      if (done) break;
    end
    start = 1'b0;
    if (!done) lat = -1;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin : main
    int lat;
    int exp_lat;
    logic [W-1:0] held;
    string tag;
    int cur_mode;

    repeat (3) @(negedge clk);
    chk("R1 result after reset", result, '0);
    chk("R1 done after reset", W'(done), '0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: empty table halts at once
    run(W'(5), 0, lat);
    chk("R1 latency with reset table", W'(lat), W'(1));
    chk("R1 result with reset table", result, '0);
    @(negedge clk);
    chk("R7 done is a single pulse", W'(done), '0);

    cur_mode = -1;
    for (int i = 0; i < NV; i++) begin
      if (int'(V_MODE[i]) != cur_mode) begin
        cur_mode = int'(V_MODE[i]);
        load_prog(cur_mode);
      end
      run(V_N[i], 0, lat);
      if (cur_mode == 1) begin
        exp_lat = 2 * int'(V_N[i]) + 3;
        tag = "R2/R6/R11 factorial";
      end else if (cur_mode == 0) begin
        exp_lat = 4;
        tag = "R4/R10 merged N*(N-1)";
      end else begin
        exp_lat = 5;
        tag = "R2/R4 four-step N*(N-1)";
      end
      chk(tag, result, V_EXP[i]);
      chk(cur_mode == 1 ? "R3 loop latency" : "R7 latency", W'(lat), W'(exp_lat));
    end

    // R8: start mid-run ignored
    load_prog(1);
    run(W'(5), 4, lat);
    chk("R8 result with stray start", result, W'(120));
    chk("R8 latency with stray start", W'(lat), W'(13));

    // R9: result holds across table writes and N changes
    held = result;
    wr(0, mkw(0, 1, 2'd1, 1, 1'b0, 3'd1, 3'd1));
    @(negedge clk);
    n_in = W'(77);
    repeat (5) @(negedge clk);
    chk("R9 result held while idle", result, held);
    chk("R9 no done while idle", W'(done), '0);

    // R5: acc load bit clear keeps accumulator, cnt still loads
    wr(0, mkw(0, 0, 2'd1, 1, 1'b0, 3'd1, 3'd1));
    wr(1, mkw(1, 0, 2'd0, 0, 1'b0, 3'd0, 3'd0));
    run(W'(99), 0, lat);
    chk("R5 accumulator holds without load", result, held);
    chk("R5 latency", W'(lat), W'(2));

    // R10: decrement of zero wraps to all ones
    wr(1, mkw(0, 1, 2'd3, 0, 1'b0, 3'd2, 3'd2));
    wr(2, mkw(1, 0, 2'd0, 0, 1'b0, 3'd0, 3'd0));
    run(W'(0), 0, lat);
    chk("R10 zero minus one wraps", result, {W{1'b1}});

    // R4: source ONE into accumulator
    wr(0, mkw(0, 1, 2'd0, 0, 1'b0, 3'd1, 3'd1));
    wr(1, mkw(1, 0, 2'd0, 0, 1'b0, 3'd0, 3'd0));
    run(W'(8), 0, lat);
    chk("R4 accumulator source one", result, W'(1));

    // R3: branch taken on zero skips a row
    wr(0, mkw(0, 0, 2'd0, 1, 1'b0, 3'd1, 3'd1)); // cnt<=N
    wr(1, mkw(0, 0, 2'd0, 0, 1'b0, 3'd2, 3'd3)); // test
    wr(2, mkw(0, 1, 2'd1, 0, 1'b0, 3'd3, 3'd3)); // acc<=N
    wr(3, mkw(1, 0, 2'd0, 0, 1'b0, 3'd0, 3'd0));
    run(W'(0), 0, lat);
    chk("R3 zero branch skips load", result, W'(1));
    chk("R3 zero branch latency", W'(lat), W'(3));
    run(W'(6), 0, lat);
    chk("R3 nonzero falls through", result, W'(6));
    chk("R3 nonzero latency", W'(lat), W'(4));

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule